// File: doc/BRIEF.md
# Extended-Range Source Capability Object Sequencer

This block produces the ordered list of 32-bit power data objects that a source port advertises once it runs in the extended power range. On a start pulse it takes a snapshot of three inputs: a table of standard-range objects, a table of extended-range fixed-voltage objects, each tagged with its voltage in volts, and one adjustable-voltage object. It then streams the list out one object per clock, with a valid strobe, a slot index and a last marker. A protocol layer that builds the message around these objects consumes the stream.

The standard-range part always fills slots 1 to 7, and any unused slot in that range carries zeros. Fixed extended-range objects are sorted by voltage in hardware, so the order of the input table does not matter. Objects whose voltage needs more power than the port can offer are removed. The power available to the port is its rating minus the wattage that sibling ports of a shared charger already draw. The adjustable object closes the list.

Top module: `epr_caps_sequencer`

## Requirements
- R1: Slot k (1..7) carries standard-range table entry k-1 whenever k is not above the standard-range count given at start.
- R2: Every slot from 1 to 7 that lies above the standard-range count carries 32'h0.
- R3: Eligible fixed extended-range objects fill slots 8 upward in ascending voltage order; equal voltages keep lower table position first; the input table order has no influence.
- R4: The adjustable object sits in the slot right after the last kept fixed object (slot 8 if none are kept); last is high on that object only, and the stream stops there.
- R5: Usable power is the rating minus the sibling-port usage, floored at zero.
- R6: An entry is eligible only when its present bit is set; a voltage of 36 V or more needs usable power of at least 140 W, and 48 V or more needs at least 180 W.
- R7: At most 6 fixed objects are sent (the lowest ones in the R3 order); overflow goes high when more are eligible and holds until the next accepted start.
- R8: An accepted start makes the first object valid in the next cycle with index 1; the index then rises by one every cycle with no gap; start while busy is ignored.
- R9: After reset valid, busy and overflow are low.
- R10: Table, rating and usage changes after the accepting edge do not alter the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new list (ignored while busy) |
| spr_objs_i | input | SPR_SLOTS*32 | Standard-range objects, entry 0 in the low word |
| spr_count_i | input | CNT_W | Number of valid standard-range entries |
| epr_objs_i | input | EPR_ENTRIES*32 | Fixed extended-range objects |
| epr_volts_i | input | EPR_ENTRIES*VOLT_W | Voltage tag of each fixed object, in volts |
| epr_present_i | input | EPR_ENTRIES | Entry-present bits |
| avs_obj_i | input | 32 | Adjustable-voltage object |
| rating_w_i | input | WATT_W | Port power rating in watts |
| other_w_i | input | WATT_W | Watts drawn by sibling ports |
| obj_valid_o | output | 1 | Object on obj_data_o is valid |
| obj_data_o | output | 32 | Current object |
| obj_index_o | output | IDX_W | Slot number of the current object |
| obj_last_o | output | 1 | Current object is the final one |
| busy_o | output | 1 | A list is being emitted |
| overflow_o | output | 1 | Fixed objects were dropped in the latest list |

## Verification
The hardest state to reach is the overflow case. It needs more eligible fixed objects than there are slots, combined with equal voltages and a scrambled table, so that both the truncation and the tie order matter at the same time. The bench fills all eight entries with voltages below the first power threshold, two of them equal, so every entry passes the filter. It then starts a list with a start pulse held across the busy window and rewrites the tables mid-stream, which shows that the ignored start and the snapshot behave together.

// File: rtl/epr_seq_pkg.sv
package epr_seq_pkg;
   localparam int OBJ_W = 32;
   typedef logic [OBJ_W-1:0] pdo_t;

   // Ordering key: lower voltage first, then lower table position
   function automatic bit goes_before(int va, int ia, int vb, int ib);
      return (va < vb) || ((va == vb) && (ia < ib));
   endfunction
endpackage

// File: rtl/epr_rate_filter.sv
module epr_rate_filter #(
   parameter int N          = 8,
   parameter int VW         = 8,
   parameter int WW         = 10,
   parameter int V_MID      = 36,
   parameter int V_HIGH     = 48,
   parameter int W_MID      = 140,
   parameter int W_HIGH     = 180,
   parameter bit SHARED_CAP = 1'b1
) (
   input  logic [N*VW-1:0] volts_i,
   input  logic [N-1:0]    present_i,
   input  logic [WW-1:0]   rating_w_i,
   input  logic [WW-1:0]   other_w_i,
   output logic [WW-1:0]   eff_w_o,
   output logic [N-1:0]    elig_o
);
   generate
      if (SHARED_CAP) begin : g_shared
         assign eff_w_o = (rating_w_i > other_w_i) ? (rating_w_i - other_w_i) : '0;
      end else begin : g_single
         logic unused_other;
         assign unused_other = ^other_w_i;
         assign eff_w_o      = rating_w_i;
      end
   endgenerate

   for (genvar g = 0; g < N; g++) begin : g_ent
      logic [VW-1:0] v;
      logic          need_high, need_mid;
      assign v         = volts_i[g*VW +: VW];
      assign need_high = (v >= VW'(V_HIGH)) && (eff_w_o < WW'(W_HIGH));
      assign need_mid  = (v >= VW'(V_MID))  && (eff_w_o < WW'(W_MID));
      assign elig_o[g] = present_i[g] && !need_high && !need_mid;
   end
endmodule

// File: rtl/epr_rank_sort.sv
module epr_rank_sort
   import epr_seq_pkg::*;
#(
   parameter int N     = 8,
   parameter int VW    = 8,
   parameter int SLOTS = 6,
   parameter int KW    = $clog2(SLOTS + 1)
) (
   input  logic [N*OBJ_W-1:0]     objs_i,
   input  logic [N*VW-1:0]        volts_i,
   input  logic [N-1:0]           elig_i,
   output logic [SLOTS*OBJ_W-1:0] slots_o,
   output logic [KW-1:0]          kept_o,
   output logic                   ovf_o
);
   localparam int RW = $clog2(N + 1);
   localparam int NW = $clog2(N + 1);

   logic [RW-1:0] rank [N];
   logic [NW-1:0] n_elig;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         rank[i] = '0;
         for (int j = 0; j < N; j++) begin
            if (j != i && elig_i[j] &&
                goes_before(int'(volts_i[j*VW +: VW]), j, int'(volts_i[i*VW +: VW]), i))
               rank[i] = rank[i] + 1'b1;
         end
      end
   end

   always_comb begin
      n_elig = '0;
      for (int i = 0; i < N; i++) n_elig = n_elig + NW'(elig_i[i]);
   end

   assign ovf_o  = (int'(n_elig) > SLOTS);
   assign kept_o = ovf_o ? KW'(SLOTS) : KW'(n_elig);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_comb begin
         slots_o[s*OBJ_W +: OBJ_W] = '0;
         for (int i = 0; i < N; i++) begin
            if (elig_i[i] && int'(rank[i]) == s)
               slots_o[s*OBJ_W +: OBJ_W] = objs_i[i*OBJ_W +: OBJ_W];
         end
      end
   end
endmodule

// File: rtl/epr_obj_stream.sv
module epr_obj_stream
   import epr_seq_pkg::*;
#(
   parameter int SPR_SLOTS = 7,
   parameter int SLOTS     = 6,
   parameter int CW        = $clog2(SPR_SLOTS + 1),
   parameter int KW        = $clog2(SLOTS + 1),
   parameter int IW        = $clog2(SPR_SLOTS + SLOTS + 2)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [SPR_SLOTS*OBJ_W-1:0] spr_objs_i,
   input  logic [CW-1:0]              spr_count_i,
   input  logic [SLOTS*OBJ_W-1:0]     slots_i,
   input  logic [KW-1:0]              kept_i,
   input  logic                       ovf_i,
   input  pdo_t                       avs_i,
   output logic                       valid_o,
   output pdo_t                       data_o,
   output logic [IW-1:0]              index_o,
   output logic                       last_o,
   output logic                       busy_o,
   output logic                       ovf_o
);
   pdo_t          spr_q  [SPR_SLOTS];
   pdo_t          slot_q [SLOTS];
   pdo_t          avs_q;
   logic [CW-1:0] cnt_q;
   logic [KW-1:0] kept_q;
   logic [IW-1:0] idx_q;
   logic          busy_q, ovf_q;
   logic          accept, at_end;

   assign accept = start_i && !busy_q;
   assign at_end = busy_q && (int'(idx_q) == SPR_SLOTS + int'(kept_q) + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SPR_SLOTS; k++) spr_q[k] <= '0;
         for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
         avs_q  <= '0;
         cnt_q  <= '0;
         kept_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else if (accept) begin
         for (int k = 0; k < SPR_SLOTS; k++) spr_q[k] <= spr_objs_i[k*OBJ_W +: OBJ_W];
         for (int k = 0; k < SLOTS; k++) slot_q[k] <= slots_i[k*OBJ_W +: OBJ_W];
         avs_q  <= avs_i;
         cnt_q  <= spr_count_i;
         kept_q <= kept_i;
         idx_q  <= IW'(1);
         busy_q <= 1'b1;
         ovf_q  <= ovf_i;
      end else if (busy_q) begin
         if (at_end) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   always_comb begin
      data_o = avs_q;
      for (int k = 0; k < SPR_SLOTS; k++) begin
         if (int'(idx_q) == k + 1)
            data_o = (k < int'(cnt_q)) ? spr_q[k] : '0;
      end
      for (int k = 0; k < SLOTS; k++) begin
         if (int'(idx_q) == SPR_SLOTS + k + 1 && k < int'(kept_q))
            data_o = slot_q[k];
      end
   end

   assign valid_o = busy_q;
   assign index_o = idx_q;
   assign last_o  = at_end;
   assign busy_o  = busy_q;
   assign ovf_o   = ovf_q;
endmodule

// File: rtl/epr_caps_sequencer.sv
module epr_caps_sequencer
   import epr_seq_pkg::*;
#(
   parameter int SPR_SLOTS   = 7,
   parameter int EPR_ENTRIES = 8,
   parameter int EPR_SLOTS   = 6,
   parameter int VOLT_W      = 8,
   parameter int WATT_W      = 10,
   parameter int V_MID       = 36,
   parameter int V_HIGH      = 48,
   parameter int W_MID       = 140,
   parameter int W_HIGH      = 180,
   parameter bit SHARED_CAP  = 1'b1,
   localparam int CNT_W      = $clog2(SPR_SLOTS + 1),
   localparam int KEPT_W     = $clog2(EPR_SLOTS + 1),
   localparam int IDX_W      = $clog2(SPR_SLOTS + EPR_SLOTS + 2)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [SPR_SLOTS*32-1:0]        spr_objs_i,
   input  logic [CNT_W-1:0]               spr_count_i,
   input  logic [EPR_ENTRIES*32-1:0]      epr_objs_i,
   input  logic [EPR_ENTRIES*VOLT_W-1:0]  epr_volts_i,
   input  logic [EPR_ENTRIES-1:0]         epr_present_i,
   input  logic [31:0]                    avs_obj_i,
   input  logic [WATT_W-1:0]              rating_w_i,
   input  logic [WATT_W-1:0]              other_w_i,
   output logic                           obj_valid_o,
   output logic [31:0]                    obj_data_o,
   output logic [IDX_W-1:0]               obj_index_o,
   output logic                           obj_last_o,
   output logic                           busy_o,
   output logic                           overflow_o
);
   if (SPR_SLOTS < 1 || EPR_SLOTS < 1 || EPR_ENTRIES < 2) begin : g_bad_depth
      $error("epr_caps_sequencer: slot and entry counts out of range");
   end
   if (V_MID > V_HIGH || W_MID > W_HIGH) begin : g_bad_tier
      $error("epr_caps_sequencer: thresholds must rise with voltage");
   end
   if ((1 << VOLT_W) <= V_HIGH || (1 << WATT_W) <= W_HIGH) begin : g_bad_width
      $error("epr_caps_sequencer: field widths too narrow for thresholds");
   end

   logic [WATT_W-1:0]          eff_w;
   logic [EPR_ENTRIES-1:0]     elig;
   logic [EPR_SLOTS*32-1:0]    sorted;
   logic [KEPT_W-1:0]          kept;
   logic                       ovf_now;

   epr_rate_filter #(
      .N(EPR_ENTRIES), .VW(VOLT_W), .WW(WATT_W),
      .V_MID(V_MID), .V_HIGH(V_HIGH), .W_MID(W_MID), .W_HIGH(W_HIGH),
      .SHARED_CAP(SHARED_CAP)
   ) u_filter (
      .volts_i(epr_volts_i), .present_i(epr_present_i),
      .rating_w_i(rating_w_i), .other_w_i(other_w_i),
      .eff_w_o(eff_w), .elig_o(elig)
   );

   epr_rank_sort #(
      .N(EPR_ENTRIES), .VW(VOLT_W), .SLOTS(EPR_SLOTS), .KW(KEPT_W)
   ) u_sort (
      .objs_i(epr_objs_i), .volts_i(epr_volts_i), .elig_i(elig),
      .slots_o(sorted), .kept_o(kept), .ovf_o(ovf_now)
   );

   logic unused_eff;
   assign unused_eff = ^eff_w;

   epr_obj_stream #(
      .SPR_SLOTS(SPR_SLOTS), .SLOTS(EPR_SLOTS),
      .CW(CNT_W), .KW(KEPT_W), .IW(IDX_W)
   ) u_stream (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .spr_objs_i(spr_objs_i), .spr_count_i(spr_count_i),
      .slots_i(sorted), .kept_i(kept), .ovf_i(ovf_now), .avs_i(avs_obj_i),
      .valid_o(obj_valid_o), .data_o(obj_data_o), .index_o(obj_index_o),
      .last_o(obj_last_o), .busy_o(busy_o), .ovf_o(overflow_o)
   );
endmodule

// File: rtl/epr_caps_sequencer_chk.sv
module epr_caps_sequencer_chk #(
   parameter int SPR_SLOTS = 7,
   parameter int IW        = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          obj_valid_o,
   input logic [IW-1:0] obj_index_o,
   input logic          obj_last_o,
   input logic          busy_o,
   input logic          overflow_o
);
   // R4: last only marks a valid object
   a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      obj_last_o |-> obj_valid_o);

   // R4: the closing object is never inside the standard-range slots
   a_r4_last_after_spr: assert property (@(posedge clk) disable iff (!rst_n)
      obj_last_o |-> (int'(obj_index_o) >= SPR_SLOTS + 1));

   // R4: stream stops after last
   a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      obj_last_o |=> !obj_valid_o);

   // R8: accepted start gives index 1 next cycle
   a_r8_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (obj_valid_o && obj_index_o == IW'(1)));

   // R8: gapless increment, start ignored mid-stream
   a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (obj_valid_o && !obj_last_o) |=> (obj_valid_o && obj_index_o == $past(obj_index_o) + 1'b1));

   // R7: overflow holds while a list is being sent
   a_r7_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && busy_o) |-> $stable(overflow_o));
endmodule

bind epr_caps_sequencer epr_caps_sequencer_chk #(.SPR_SLOTS(SPR_SLOTS), .IW(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i),
   .obj_valid_o(obj_valid_o), .obj_index_o(obj_index_o), .obj_last_o(obj_last_o),
   .busy_o(busy_o), .overflow_o(overflow_o)
);

// File: tb/epr_caps_sequencer_bench.sv
module epr_caps_sequencer_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        start = 1'b0;
   logic [31:0] spr [7];
   logic [2:0]  spr_cnt;
   logic [31:0] eo [8];
   logic [7:0]  ev [8];
   logic [7:0]  ep;
   logic [31:0] avs;
   logic [9:0]  rating, other;

   logic [7*32-1:0] spr_flat;
   logic [8*32-1:0] eo_flat;
   logic [8*8-1:0]  ev_flat;
   always_comb begin
      for (int k = 0; k < 7; k++) spr_flat[k*32 +: 32] = spr[k];
      for (int k = 0; k < 8; k++) begin
         eo_flat[k*32 +: 32] = eo[k];
         ev_flat[k*8 +: 8]   = ev[k];
      end
   end

   logic        valid, last, busy, ovf;
   logic [31:0] data;
   logic [3:0]  index;

   epr_caps_sequencer u_epr_caps_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .spr_objs_i(spr_flat), .spr_count_i(spr_cnt),
      .epr_objs_i(eo_flat), .epr_volts_i(ev_flat), .epr_present_i(ep),
      .avs_obj_i(avs), .rating_w_i(rating), .other_w_i(other),
      .obj_valid_o(valid), .obj_data_o(data), .obj_index_o(index),
      .obj_last_o(last), .busy_o(busy), .overflow_o(ovf)
   );

   typedef struct { logic [31:0] d; int idx; string tag; } exp_t;
   exp_t  q[$];
   bit    exp_ovf;
   string epr_tag = "R3";
   string all_tag = "";
   int    checks = 0;
   int    errors = 0;
   bit    armed = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic void build();
      exp_t e;
      int   eff;
      int   sel[$];
      int   kept;
      q.delete();
      eff = (rating > other) ? int'(rating) - int'(other) : 0;
      for (int k = 0; k < 7; k++) begin
         e.d   = (k < int'(spr_cnt)) ? spr[k] : 32'h0;
         e.idx = k + 1;
         e.tag = (k < int'(spr_cnt)) ? "R1" : "R2";
         q.push_back(e);
      end
      for (int i = 0; i < 8; i++) begin
         int v;
         v = int'(ev[i]);
         if (ep[i] && !(v >= 48 && eff < 180) && !(v >= 36 && eff < 140)) begin
            int p;
            p = sel.size();
            for (int s = sel.size() - 1; s >= 0; s--)
               if (int'(ev[sel[s]]) > v) p = s;
            sel.insert(p, i);
         end
      end
      exp_ovf = (sel.size() > 6);
      kept = exp_ovf ? 6 : sel.size();
      for (int p = 0; p < kept; p++) begin
         e.d = eo[sel[p]]; e.idx = 8 + p; e.tag = epr_tag;
         q.push_back(e);
      end
      e.d = avs; e.idx = 8 + kept; e.tag = "R4";
      q.push_back(e);
      if (all_tag != "")
         for (int k = 0; k < q.size(); k++) q[k].tag = all_tag;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         exp_ovf = 0;
      end else if (q.size() > 0) begin
         void'(q.pop_front());
      end else if (start) begin
         build();
      end
   end

   always @(negedge clk) begin
      if (rst_n && armed) begin
         chk(valid == (q.size() > 0), "R8", "valid", 32'(valid), 32'(q.size() > 0));
         chk(busy == (q.size() > 0), "R8", "busy", 32'(busy), 32'(q.size() > 0));
         chk(ovf == exp_ovf, "R7", "overflow", 32'(ovf), 32'(exp_ovf));
         if (q.size() > 0) begin
            chk(data == q[0].d, q[0].tag, "data", data, q[0].d);
            chk(int'(index) == q[0].idx, "R8", "index", 32'(index), 32'(q[0].idx));
            chk(last == (q.size() == 1), "R4", "last", 32'(last), 32'(q.size() == 1));
         end
      end
   end

   task automatic set_ent(int i, int volt, bit pres);
      ev[i] = 8'(volt);
      eo[i] = 32'hC000_0000 | (32'(volt) << 16) | 32'(i);
      ep[i] = pres;
   endtask

   task automatic run_one(string tag);
      epr_tag = tag;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 7; k++) spr[k] = 32'h1000_0000 + 32'(k * 17 + 3);
      spr_cnt = 3'd7;
      ep = 8'h00;
      for (int i = 0; i < 8; i++) set_ent(i, 0, 1'b0);
      avs = 32'hA5A5_0F0F;
      rating = 10'd240; other = 10'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(valid == 1'b0, "R9", "valid", 32'(valid), 32'h0);
      chk(busy == 1'b0, "R9", "busy", 32'(busy), 32'h0);
      chk(ovf == 1'b0, "R9", "overflow", 32'(ovf), 32'h0);
      armed = 1;

      // R3: scrambled voltages, full power, all kept in ascending order
      set_ent(0, 48, 1); set_ent(1, 28, 1); set_ent(2, 36, 1); set_ent(3, 40, 1);
      run_one("R3");

      // R6 + R2: 150 W drops the 48 V object; only three standard entries
      spr_cnt = 3'd3; rating = 10'd150;
      set_ent(4, 30, 0);
      run_one("R6");

      // R5: shared charger, 250 - 120 = 130 W leaves only 28 V
      spr_cnt = 3'd5; rating = 10'd250; other = 10'd120;
      run_one("R5");

      // R5: usage above rating floors at zero; no standard entries
      spr_cnt = 3'd0; rating = 10'd100; other = 10'd200;
      run_one("R5");

      // R7: eight eligible entries with a tie, two dropped
      spr_cnt = 3'd7; rating = 10'd240; other = 10'd0;
      set_ent(0, 28, 1); set_ent(1, 30, 1); set_ent(2, 28, 1); set_ent(3, 32, 1);
      set_ent(4, 34, 1); set_ent(5, 29, 1); set_ent(6, 31, 1); set_ent(7, 33, 1);
      run_one("R7");

      // R10 + R8: start held while busy, inputs rewritten mid-stream
      for (int i = 4; i < 8; i++) ep[i] = 1'b0;
      all_tag = "R10";
      @(negedge clk) start = 1'b1;
      @(negedge clk);
      spr[0] = 32'hDEAD_0000; set_ent(1, 50, 1); rating = 10'd60; avs = 32'h1234_5678;
      @(negedge clk);
      spr_cnt = 3'd1; ep = 8'hFF;
      @(negedge clk) start = 1'b0;
      while (q.size() > 0) @(negedge clk);
      all_tag = "";
      @(negedge clk);

      // R8: start held across the end of a list restarts after one idle cycle
      rating = 10'd200; ep = 8'h0F; spr_cnt = 3'd6;
      @(negedge clk) start = 1'b1;
      epr_tag = "R3";
      while (q.size() == 0) @(negedge clk);
      while (q.size() > 0) @(negedge clk);
      @(negedge clk) start = 1'b0;
      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);

      finish_run();
   end
endmodule